// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides a vectorised conditional branch. After a start strobe it walks a vector of 4-bit condition fields, one element per clock, in ascending index order from 0 up to the vector length minus one. From each element it picks one condition bit, compares it against a sense bit (or forces a pass), and folds the outcome into a single branch decision. In "all" mode every tested element must pass. Otherwise the first passing element decides the branch.

A per-element predicate either drops an element completely or replaces its condition bit with a chosen constant. Evaluation stops at the first decisive element, so later elements are never tested. On request, the block reports a truncated vector length at the first element whose outcome matches a chosen polarity, with that element either counted or not. It also reports how many elements were really tested, so that a loop counter can be reduced by that number. A scalar option tests only the first element that is not dropped, always against field 0. All inputs are captured at the start strobe.

Top module: `vbranch_eval`

## Requirements
- R1: Element i uses field `fields_in[4*i +: 4]`. The bit tested is bit `bit_sel` of that field, where bit 0 is less-than, bit 1 greater-than, bit 2 equal and bit 3 overflow.
- R2: An element passes when `force_pass` is 1 or when the tested bit equals `sense`.
- R3: With `all_mode`=1 the decision starts at 1 and is ANDed with each tested element. The first failing element ends the walk.
- R4: With `all_mode`=0 the decision starts at 0 and is ORed with each tested element. The first passing element ends the walk.
- R5: An element whose predicate bit is 0 while `zero_sub`=0 is skipped. It does not change the decision and is not counted.
- R6: An element whose predicate bit is 0 while `zero_sub`=1 is tested with `subst_val` in place of its condition bit, and it is counted.
- R7: With `trunc_en`=1, the first tested element i whose outcome equals `trunc_on` ends the walk. It sets `newvl_valid`=1 and sets `newvl` to i+1 when `trunc_incl`=1, or to i when it is 0. In all other cases `newvl_valid`=0.
- R8: With `scalar_sel`=1 every element reads field 0, and the walk ends after the first element that is not skipped.
- R9: `tested_cnt` equals the number of elements tested (not skipped) before the walk ended.
- R10: One element is handled per clock. `done` is a one-cycle pulse, L+1 cycles after the clock edge that samples `start`, where L is the last index handled. With a vector length of 0, `done` rises right after that edge with the initial decision, a count of 0 and no new length.
- R11: `start` is ignored while a walk is in progress. The results hold from `done` until the next accepted start.
- R12: A `vl_in` value above MAX_VL is treated as MAX_VL.
- R13: After reset, `done`, `cond_ok`, `tested_cnt`, `newvl_valid` and `newvl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk, capturing all inputs |
| vl_in | input | VW | Vector length |
| pred_in | input | MAX_VL | Predicate mask, bit i for element i |
| fields_in | input | 4*MAX_VL | Flat vector of condition fields |
| bit_sel | input | 2 | Bit of each field to test |
| force_pass | input | 1 | Every tested element passes |
| sense | input | 1 | Bit value that counts as a pass |
| all_mode | input | 1 | 1: all must pass, 0: any passes |
| zero_sub | input | 1 | Substitute masked elements instead of skipping them |
| subst_val | input | 1 | Value substituted for masked elements |
| trunc_en | input | 1 | Enable vector-length truncation |
| trunc_on | input | 1 | Outcome that triggers truncation |
| trunc_incl | input | 1 | New length includes the deciding element |
| scalar_sel | input | 1 | Scalar field selector |
| done | output | 1 | One-cycle completion pulse |
| cond_ok | output | 1 | Branch decision |
| tested_cnt | output | VW | Number of tested elements |
| newvl_valid | output | 1 | A truncated length was produced |
| newvl | output | VW | Truncated vector length |

## Verification
The hardest case to reach from the ports is a start strobe that arrives in the middle of a walk, which must be ignored. The bench sets up a long all-pass walk and raises start with a different length partway through, then checks that the results match the first request. A second hard area is masked elements mixed with early exits and truncation, where the latency, the count and the new length all depend on exactly which index decided. Random masks, fields and mode bits are compared against a step-by-step model. Directed cases pin the included and excluded truncation lengths and the scalar case where element 0 is masked.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
    localparam int FIELD_W = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vbe_state_e;

    typedef struct packed {
        logic       all_mode;
        logic       zero_sub;
        logic       subst_val;
        logic       trunc_en;
        logic       trunc_on;
        logic       trunc_incl;
        logic       scalar_sel;
        logic       force_pass;
        logic       sense;
        logic [1:0] bit_sel;
    } vbe_mode_t;
endpackage

// File: rtl/vbe_field_pick.sv
module vbe_field_pick
    import vbe_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int VW     = $clog2(MAX_VL + 1)
) (
    input  logic [MAX_VL*FIELD_W-1:0] fields,
    input  logic [MAX_VL-1:0]         preds,
    input  logic [VW-1:0]             idx,
    input  logic                      scalar_sel,
    output logic [FIELD_W-1:0]        field,
    output logic                      pred_bit
);
    localparam int AW = $clog2(MAX_VL);

    logic [FIELD_W-1:0] fa [MAX_VL];
    logic [AW-1:0]      addr;
    logic               in_range;

    for (genvar g = 0; g < MAX_VL; g++) begin : g_unpack
        assign fa[g] = fields[g*FIELD_W +: FIELD_W];
    end

    always_comb begin
        in_range = (idx < VW'(MAX_VL));
        addr     = in_range ? idx[AW-1:0] : '0;
        field    = scalar_sel ? fa[0] : fa[addr];
        pred_bit = in_range ? preds[addr] : 1'b0;
    end
endmodule

// File: rtl/vbe_elem_test.sv
module vbe_elem_test
    import vbe_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               pred_bit,
    input  logic [1:0]         bit_sel,
    input  logic               force_pass,
    input  logic               sense,
    input  logic               zero_sub,
    input  logic               subst_val,
    output logic               skip,
    output logic               el_ok
);
    logic test_bit;

    always_comb begin
        test_bit = pred_bit ? field[bit_sel] : subst_val;
        skip     = !pred_bit && !zero_sub;
        el_ok    = force_pass || (test_bit == sense);
    end
endmodule

// File: rtl/vbe_ctrl.sv
module vbe_ctrl
    import vbe_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int VW     = $clog2(MAX_VL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [VW-1:0]             vl_in,
    input  logic [MAX_VL-1:0]         pred_in,
    input  logic [MAX_VL*FIELD_W-1:0] fields_in,
    input  vbe_mode_t                 mode_in,
    input  logic                      el_skip,
    input  logic                      el_ok,
    output logic [VW-1:0]             idx,
    output logic [MAX_VL-1:0]         pred_vec,
    output logic [MAX_VL*FIELD_W-1:0] field_vec,
    output vbe_mode_t                 mode,
    output logic                      done,
    output logic                      cond_ok,
    output logic [VW-1:0]             tested_cnt,
    output logic                      newvl_valid,
    output logic [VW-1:0]             newvl
);
    localparam logic [VW-1:0] ONE    = VW'(1);
    localparam logic [VW-1:0] VL_CAP = VW'(MAX_VL);

    typedef struct packed {
        vbe_state_e                st;
        logic [VW-1:0]             idx;
        logic [VW-1:0]             vl;
        logic [VW-1:0]             cnt;
        logic [VW-1:0]             nv;
        logic                      acc;
        logic                      done;
        logic                      nvv;
        vbe_mode_t                 mode;
        logic [MAX_VL-1:0]         pred;
        logic [MAX_VL*FIELD_W-1:0] fld;
    } ctrl_t;

    ctrl_t q, d;
    logic  stop;
    logic  run;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        stop   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.vl   = (vl_in > VL_CAP) ? VL_CAP : vl_in;
                    d.pred = pred_in;
                    d.fld  = fields_in;
                    d.mode = mode_in;
                    d.idx  = '0;
                    d.cnt  = '0;
                    d.nv   = '0;
                    d.nvv  = 1'b0;
                    d.acc  = mode_in.all_mode;
                    if (vl_in == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!el_skip) begin
                    d.cnt = q.cnt + ONE;
                    d.acc = q.mode.all_mode ? (q.acc && el_ok) : (q.acc || el_ok);
                    if (q.mode.trunc_en && (el_ok == q.mode.trunc_on)) begin
                        d.nvv = 1'b1;
                        d.nv  = q.mode.trunc_incl ? (q.idx + ONE) : q.idx;
                        stop  = 1'b1;
                    end
                    if (q.mode.all_mode && !el_ok) stop = 1'b1;
                    if (!q.mode.all_mode && el_ok) stop = 1'b1;
                    if (q.mode.scalar_sel)         stop = 1'b1;
                end
                if (q.idx == q.vl - ONE) stop = 1'b1;
                if (stop) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.idx = q.idx + ONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run         = (q.st == ST_RUN);
    assign idx         = q.idx;
    assign pred_vec    = q.pred;
    assign field_vec   = q.fld;
    assign mode        = q.mode;
    assign done        = q.done;
    assign cond_ok     = q.acc;
    assign tested_cnt  = q.cnt;
    assign newvl_valid = q.nvv;
    assign newvl       = q.nv;

    // R4: a passing element in any mode finishes the walk on the next edge
    a_r4_any_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !q.mode.all_mode && !el_skip && el_ok) |=> (done && cond_ok));

    // R3: a failing element in all mode finishes with a failed decision
    a_r3_all_fail_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.mode.all_mode && !el_skip && !el_ok) |=> (done && !cond_ok));

    // R5: a skipped element leaves the tested count alone
    a_r5_skip_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (run && el_skip) |=> (tested_cnt == $past(tested_cnt)));

    // R10: the walk advances by exactly one index per clock
    a_r10_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || (idx == $past(idx) + ONE)));

    // R11: a start during a walk does not reload the length
    a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start) |=> (q.vl == $past(q.vl)));

    // R7: a truncated length never exceeds the captured length
    a_r7_newvl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && newvl_valid) |-> (newvl <= q.vl));

    // R9: the tested count never exceeds the captured length
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tested_cnt <= q.vl));
endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
    import vbe_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int VW     = $clog2(MAX_VL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [VW-1:0]             vl_in,
    input  logic [MAX_VL-1:0]         pred_in,
    input  logic [MAX_VL*FIELD_W-1:0] fields_in,
    input  logic [1:0]                bit_sel,
    input  logic                      force_pass,
    input  logic                      sense,
    input  logic                      all_mode,
    input  logic                      zero_sub,
    input  logic                      subst_val,
    input  logic                      trunc_en,
    input  logic                      trunc_on,
    input  logic                      trunc_incl,
    input  logic                      scalar_sel,
    output logic                      done,
    output logic                      cond_ok,
    output logic [VW-1:0]             tested_cnt,
    output logic                      newvl_valid,
    output logic [VW-1:0]             newvl
);
    vbe_mode_t                 mode_in, mode_q;
    logic [VW-1:0]             idx;
    logic [MAX_VL-1:0]         pred_vec;
    logic [MAX_VL*FIELD_W-1:0] field_vec;
    logic [FIELD_W-1:0]        cur_field;
    logic                      cur_pred;
    logic                      el_skip;
    logic                      el_ok;

    always_comb begin
        mode_in.all_mode   = all_mode;
        mode_in.zero_sub   = zero_sub;
        mode_in.subst_val  = subst_val;
        mode_in.trunc_en   = trunc_en;
        mode_in.trunc_on   = trunc_on;
        mode_in.trunc_incl = trunc_incl;
        mode_in.scalar_sel = scalar_sel;
        mode_in.force_pass = force_pass;
        mode_in.sense      = sense;
        mode_in.bit_sel    = bit_sel;
    end

    vbe_ctrl #(.MAX_VL(MAX_VL), .VW(VW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vl_in       (vl_in),
        .pred_in     (pred_in),
        .fields_in   (fields_in),
        .mode_in     (mode_in),
        .el_skip     (el_skip),
        .el_ok       (el_ok),
        .idx         (idx),
        .pred_vec    (pred_vec),
        .field_vec   (field_vec),
        .mode        (mode_q),
        .done        (done),
        .cond_ok     (cond_ok),
        .tested_cnt  (tested_cnt),
        .newvl_valid (newvl_valid),
        .newvl       (newvl)
    );

    vbe_field_pick #(.MAX_VL(MAX_VL), .VW(VW)) u_pick (
        .fields     (field_vec),
        .preds      (pred_vec),
        .idx        (idx),
        .scalar_sel (mode_q.scalar_sel),
        .field      (cur_field),
        .pred_bit   (cur_pred)
    );

    vbe_elem_test u_test (
        .field      (cur_field),
        .pred_bit   (cur_pred),
        .bit_sel    (mode_q.bit_sel),
        .force_pass (mode_q.force_pass),
        .sense      (mode_q.sense),
        .zero_sub   (mode_q.zero_sub),
        .subst_val  (mode_q.subst_val),
        .skip       (el_skip),
        .el_ok      (el_ok)
    );
endmodule

// File: tb/tb_vbranch_eval.sv
`timescale 1ns/1ps
module tb_vbranch_eval;
    localparam int MAXV = 16;
    localparam int VW   = $clog2(MAXV + 1);
    localparam realtime HALF = 2.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VW-1:0]     vl_in = '0;
    logic [MAXV-1:0]   pred_in = '0;
    logic [MAXV*4-1:0] fields_in = '0;
    logic [1:0] bit_sel = '0;
    logic force_pass = 0, sense = 0, all_mode = 0, zero_sub = 0, subst_val = 0;
    logic trunc_en = 0, trunc_on = 0, trunc_incl = 0, scalar_sel = 0;
    logic done, cond_ok, newvl_valid;
    logic [VW-1:0] tested_cnt, newvl;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(HALF) clk = ~clk;

    vbranch_eval #(.MAX_VL(MAXV)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .pred_in(pred_in), .fields_in(fields_in), .bit_sel(bit_sel),
        .force_pass(force_pass), .sense(sense), .all_mode(all_mode),
        .zero_sub(zero_sub), .subst_val(subst_val), .trunc_en(trunc_en),
        .trunc_on(trunc_on), .trunc_incl(trunc_incl), .scalar_sel(scalar_sel),
        .done(done), .cond_ok(cond_ok), .tested_cnt(tested_cnt),
        .newvl_valid(newvl_valid), .newvl(newvl)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model(output bit e_cond, output int e_cnt,
                                  output bit e_nvv, output int e_nv, output int e_lat);
        int v;
        v = (int'(vl_in) > MAXV) ? MAXV : int'(vl_in);
        e_cond = all_mode;
        e_cnt = 0; e_nvv = 0; e_nv = 0;
        e_lat = v;
        for (int i = 0; i < v; i++) begin
            logic [3:0] fld;
            bit tb, el, stp;
            fld = fields_in[(scalar_sel ? 0 : i)*4 +: 4];
            if (!pred_in[i] && !zero_sub) continue;
            tb = pred_in[i] ? fld[bit_sel] : subst_val;
            el = force_pass || (tb == sense);
            e_cnt++;
            e_cond = all_mode ? (e_cond && el) : (e_cond || el);
            stp = 0;
            if (trunc_en && (el == trunc_on)) begin
                e_nvv = 1;
                e_nv = trunc_incl ? i + 1 : i;
                stp = 1;
            end
            if (all_mode && !el) stp = 1;
            if (!all_mode && el) stp = 1;
            if (scalar_sel) stp = 1;
            if (stp) begin
                e_lat = i + 1;
                break;
            end
        end
    endfunction

    task automatic run_case(input string tag, input bit glitch);
        bit e_cond, e_nvv;
        int e_cnt, e_nv, e_lat, cyc;
        logic [VW-1:0] saved_vl;
        model(e_cond, e_cnt, e_nvv, e_nv, e_lat);
        saved_vl = vl_in;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            if (glitch && cyc == 2) begin
                start = 1'b1; vl_in = '0;
            end else if (glitch && cyc == 3) begin
                start = 1'b0; vl_in = saved_vl;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        vl_in = saved_vl;
        check(tag, "latency", cyc, e_lat);
        check(tag, "cond_ok", int'(cond_ok), int'(e_cond));
        check(tag, "tested_cnt", int'(tested_cnt), e_cnt);
        check(tag, "newvl_valid", int'(newvl_valid), int'(e_nvv));
        if (e_nvv) check(tag, "newvl", int'(newvl), e_nv);
        @(negedge clk);
        check(tag, "done pulse width", int'(done), 0);
        check(tag, "result hold", int'(cond_ok), int'(e_cond));
    endtask

    task automatic clear_cfg();
        force_pass = 0; sense = 1; all_mode = 0; zero_sub = 0; subst_val = 0;
        trunc_en = 0; trunc_on = 0; trunc_incl = 0; scalar_sel = 0;
        bit_sel = 2'd0; pred_in = '1; fields_in = '0; vl_in = '0;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_cfg();
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13", "done", int'(done), 0);
        check("R13", "cond_ok", int'(cond_ok), 0);
        check("R13", "tested_cnt", int'(tested_cnt), 0);
        check("R13", "newvl_valid", int'(newvl_valid), 0);
        check("R13", "newvl", int'(newvl), 0);
        rst_n = 1'b1;

        // R1: field 0 holds EQ only; selecting EQ passes, LT fails
        clear_cfg(); vl_in = 1; fields_in[3:0] = 4'b0100; bit_sel = 2'd2;
        run_case("R1", 0);
        check("R1", "eq bit pass", int'(cond_ok), 1);
        bit_sel = 2'd0; run_case("R1", 0);
        check("R1", "lt bit fail", int'(cond_ok), 0);
        // R1: element 3 uses its own field (SO bit)
        clear_cfg(); vl_in = 6; fields_in[15:12] = 4'b1000; bit_sel = 2'd3;
        run_case("R1", 0);
        check("R1", "elem3 count", int'(tested_cnt), 4);

        // R2: forced pass with all-zero fields
        clear_cfg(); vl_in = 3; force_pass = 1; run_case("R2", 0);
        check("R2", "forced pass", int'(cond_ok), 1);
        // R2: sense 0 passes on a zero bit
        clear_cfg(); vl_in = 3; sense = 0; all_mode = 1; run_case("R2", 0);
        check("R2", "sense zero", int'(cond_ok), 1);

        // R3: all mode, element 3 fails
        clear_cfg(); all_mode = 1; vl_in = 8; fields_in = {MAXV{4'b0001}};
        fields_in[12] = 1'b0; run_case("R3", 0);
        check("R3", "stop at 3 count", int'(tested_cnt), 4);

        // R4: any mode, first pass at element 5
        clear_cfg(); vl_in = 10; fields_in[20] = 1'b1; fields_in[32] = 1'b1;
        run_case("R4", 0);
        check("R4", "stop at 5 count", int'(tested_cnt), 6);

        // R5: masked passing elements are skipped
        clear_cfg(); vl_in = 6; pred_in = 16'hFFF8; fields_in[11:0] = 12'hFFF;
        run_case("R5", 0);
        check("R5", "skipped none passing", int'(cond_ok), 0);

        // R6: substitution of 1 in all mode, all masked
        clear_cfg(); all_mode = 1; zero_sub = 1; subst_val = 1; pred_in = '0; vl_in = 5;
        run_case("R6", 0);
        check("R6", "substituted count", int'(tested_cnt), 5);

        // R7: truncation on fail, included and excluded
        clear_cfg(); all_mode = 1; trunc_en = 1; trunc_on = 0; trunc_incl = 1;
        vl_in = 12; fields_in = {MAXV{4'b0001}}; fields_in[28] = 1'b0;
        run_case("R7", 0);
        check("R7", "incl newvl", int'(newvl), 8);
        trunc_incl = 0; run_case("R7", 0);
        check("R7", "excl newvl", int'(newvl), 7);
        // R7: truncation on first pass in any mode
        clear_cfg(); trunc_en = 1; trunc_on = 1; trunc_incl = 1; vl_in = 9;
        fields_in[8] = 1'b1; run_case("R7", 0);
        check("R7", "pass newvl", int'(newvl), 3);

        // R8: scalar, element 0 masked, field 0 used for element 1
        clear_cfg(); scalar_sel = 1; vl_in = 8; pred_in = 16'hFFFE;
        fields_in[0] = 1'b1; run_case("R8", 0);
        check("R8", "scalar field0", int'(cond_ok), 1);
        check("R8", "scalar count", int'(tested_cnt), 1);

        // R10: zero length
        clear_cfg(); all_mode = 1; vl_in = 0; run_case("R10", 0);
        check("R10", "zero length all", int'(cond_ok), 1);

        // R11: start during a walk is ignored
        clear_cfg(); all_mode = 1; vl_in = 10; fields_in = {MAXV{4'b0001}};
        run_case("R11", 1);
        check("R11", "full count", int'(tested_cnt), 10);

        // R12: clamp above MAX_VL
        clear_cfg(); all_mode = 1; vl_in = VW'(MAXV + 4); fields_in = {MAXV{4'b0001}};
        run_case("R12", 0);
        check("R12", "clamped count", int'(tested_cnt), MAXV);

        // R9: random mix against the model
        for (int t = 0; t < 400; t++) begin
            vl_in = VW'($urandom_range(0, MAXV + 4));
            pred_in = MAXV'($urandom);
            if ($urandom_range(0, 3) == 0) pred_in = '1;
            for (int k = 0; k < MAXV; k++) begin
                fields_in[k*4 +: 4] = 4'($urandom);
                if ($urandom_range(0, 1) == 0) fields_in[k*4 +: 4] = '1;
            end
            bit_sel = 2'($urandom);
            force_pass = ($urandom_range(0, 7) == 0);
            sense = 1'($urandom);
            all_mode = 1'($urandom);
            zero_sub = 1'($urandom);
            subst_val = 1'($urandom);
            trunc_en = 1'($urandom);
            trunc_on = 1'($urandom);
            trunc_incl = 1'($urandom);
            scalar_sel = ($urandom_range(0, 5) == 0);
            run_case("R9", 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule